// File: doc/BRIEF.md
# Serial Transmit Engine with Clear-to-Send Flow Control

This block turns bytes into an asynchronous serial line. It takes characters from a show-ahead FIFO through a valid/pop pair. Each character goes out as a frame: one start bit, eight data bits least significant first, an optional parity bit, and one or two stop bits. Time is counted in sub-ticks of a bit-clock enable that runs at sixteen times the baud rate, so every bit lasts sixteen enabled cycles.

Between characters the engine looks at an active-low clear-to-send input, which it samples on the enable. A bypass control makes it ignore that input. The sampled level and a sticky change flag are brought out so software can raise an interrupt on them. Three debug and line controls sit in front of the output pin: a parity corruption bit, a break control that holds the line at zero, and an infrared encoder. The encoder turns each zero bit into a short pulse of selectable polarity. Clearing the enable lets the current character finish, and the busy output shows when the line has gone quiet.

Top module: `uart_tx_engine`

## Requirements
- R1: A frame is a low start bit, then data bits 0 to 7 in ascending order, then one stop bit at level 1, or two when `two_stop` is 1. Each bit lasts 16 `bit_tick` pulses.
- R2: When `parity_en` is 1, a parity bit goes between the data and the stop bits. It is the XOR of the data bits when `parity_odd` is 0, and its inverse when `parity_odd` is 1.
- R3: When `force_perr` is 1, the transmitted parity bit is the inverse of the value given by R2.
- R4: A frame starts only while the sampled `cts_level` is 0. If `cts_n` rises during a frame, that frame still completes, and no further frame starts while the level stays 1.
- R5: When `cts_bypass` is 1, frames start regardless of `cts_n`.
- R6: `cts_level` takes the value of `cts_n` on each `bit_tick` and holds otherwise. `cts_delta` sets when a tick samples a level different from `cts_level`. A `cts_delta_clr` pulse clears it, and setting wins over clearing. After reset `cts_level` is 1 and `cts_delta` is 0.
- R7: While `send_break` is 1, the bit value before encoding is 0, so with `irda_en` at 0 `txd` is 0.
- R8: With `tx_en` at 0 no frame starts. Clearing `tx_en` mid-frame lets that frame finish in full.
- R9: Each frame produces exactly one single-cycle `fifo_pop` pulse, on the edge where the frame starts. `busy` is 1 from that edge until the end of the last stop bit, 16 times the frame's bit count later.
- R10: With `irda_en` at 1, a zero bit is a pulse lasting the first 3 of its 16 sub-ticks and a one bit sends no pulse. The pulse is high on an idle-low line when `irda_inv` is 0, and low on an idle-high line when `irda_inv` is 1.
- R11: After reset, `txd` is 1, and `busy` and `fifo_pop` are 0.
- R12: Nothing advances without `bit_tick`. A frame can begin only on a tick while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Sub-bit enable, 16 per bit |
| tx_en | input | 1 | Transmit enable |
| fifo_valid | input | 1 | FIFO holds a character |
| fifo_data | input | 8 | Head-of-FIFO character |
| fifo_pop | output | 1 | Removes the head character |
| cts_n | input | 1 | Clear-to-send, active low |
| cts_bypass | input | 1 | Ignore clear-to-send |
| cts_delta_clr | input | 1 | Clear the change flag |
| cts_level | output | 1 | Sampled clear-to-send level |
| cts_delta | output | 1 | Sticky clear-to-send change flag |
| parity_en | input | 1 | Insert parity bit |
| parity_odd | input | 1 | Odd parity select |
| two_stop | input | 1 | Two stop bits |
| force_perr | input | 1 | Invert parity bit |
| send_break | input | 1 | Hold line at zero |
| irda_en | input | 1 | Infrared pulse encoding |
| irda_inv | input | 1 | Active-low pulses, idle high |
| txd | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |

## Verification
The properties assume the FIFO side behaves as a show-ahead queue: `fifo_data` is valid and stable whenever `fifo_valid` is 1, and `fifo_valid` does not drop until the pop is seen. They also assume that the frame options and the encoder controls change only while `busy` is 0. The bench meets both assumptions. It presents one character, lowers `fifo_valid` in the cycle after the pop, and changes frame settings only between frames. The only inputs it changes mid-frame are `cts_n` and `tx_en`, which the engine is meant to tolerate there.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;
endpackage

// File: rtl/cts_sampler.sv
`timescale 1ns/1ps
module cts_sampler #(
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cts_n,
  input  logic clr,
  output logic level,
  output logic delta
);
  logic change;
  assign change = tick && (cts_n != level);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= RST_LEVEL;
      delta <= 1'b0;
    end else begin
      if (tick) level <= cts_n;
      if (change)   delta <= 1'b1;
      else if (clr) delta <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_sequencer.sv
`timescale 1ns/1ps
module tx_sequencer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int SUB_W = $clog2(OVS),
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tx_en,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              cts_ok,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              two_stop,
  input  logic              force_perr,
  output logic              fifo_pop,
  output logic              busy,
  output logic              raw_bit,
  output logic [SUB_W-1:0]  sub
);
  tx_state_t         state, state_n;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              extra_stop;
  logic              start;
  logic              bit_end;

  assign start   = tick && (state == ST_IDLE) && tx_en && fifo_valid && cts_ok;
  assign bit_end = tick && (state != ST_IDLE) && (sub == SUB_W'(OVS - 1));

  always_comb begin
    state_n = state;
    if (start) begin
      state_n = ST_START;
    end else if (bit_end) begin
      case (state)
        ST_START: state_n = ST_DATA;
        ST_DATA:  if (idx == IDX_W'(DATA_W - 1)) state_n = parity_en ? ST_PAR : ST_STOP;
        ST_PAR:   state_n = ST_STOP;
        ST_STOP:  state_n = extra_stop ? ST_STOP : ST_IDLE;
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sub        <= '0;
      idx        <= '0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      extra_stop <= 1'b0;
      fifo_pop   <= 1'b0;
      busy       <= 1'b0;
    end else begin
      state    <= state_n;
      fifo_pop <= start;
      busy     <= (state_n != ST_IDLE);
      if (start) begin
        sub        <= '0;
        idx        <= '0;
        shreg      <= fifo_data;
        par_bit    <= (^fifo_data) ^ parity_odd ^ force_perr;
        extra_stop <= two_stop;
      end else if (tick && state != ST_IDLE) begin
        sub <= (sub == SUB_W'(OVS - 1)) ? '0 : sub + 1'b1;
        if (bit_end) begin
          if (state == ST_DATA) begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
          end
          if (state == ST_STOP) extra_stop <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (state)
      ST_START: raw_bit = 1'b0;
      ST_DATA:  raw_bit = shreg[0];
      ST_PAR:   raw_bit = par_bit;
      default:  raw_bit = 1'b1;
    endcase
  end
endmodule

// File: rtl/tx_line_encoder.sv
`timescale 1ns/1ps
module tx_line_encoder #(
  parameter int OVS        = 16,
  parameter int PULSE_SUBS = 3,
  localparam int SUB_W     = $clog2(OVS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_bit,
  input  logic [SUB_W-1:0] sub,
  input  logic             send_break,
  input  logic             irda_en,
  input  logic             irda_inv,
  output logic             txd
);
  logic line_bit;
  logic pulse;

  assign line_bit = raw_bit & ~send_break;
  assign pulse    = ~line_bit && (sub < SUB_W'(PULSE_SUBS));

  always_ff @(posedge clk) begin
    if (rst)          txd <= 1'b1;
    else if (irda_en) txd <= pulse ^ irda_inv;
    else              txd <= line_bit;
  end
endmodule

// File: rtl/uart_tx_engine.sv
`timescale 1ns/1ps
module uart_tx_engine #(
  parameter int DATA_W     = 8,
  parameter int OVS        = 16,
  parameter int PULSE_SUBS = 3,
  localparam int SUB_W     = $clog2(OVS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  input  logic              cts_n,
  input  logic              cts_bypass,
  input  logic              cts_delta_clr,
  output logic              cts_level,
  output logic              cts_delta,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              two_stop,
  input  logic              force_perr,
  input  logic              send_break,
  input  logic              irda_en,
  input  logic              irda_inv,
  output logic              txd,
  output logic              busy
);
  logic             raw_bit;
  logic [SUB_W-1:0] sub;
  logic             cts_ok;

  assign cts_ok = cts_bypass | ~cts_level;

  cts_sampler #(.RST_LEVEL(1'b1)) u_cts (
    .clk(clk), .rst(rst), .tick(bit_tick), .cts_n(cts_n),
    .clr(cts_delta_clr), .level(cts_level), .delta(cts_delta)
  );

  tx_sequencer #(.DATA_W(DATA_W), .OVS(OVS)) u_seq (
    .clk(clk), .rst(rst), .tick(bit_tick), .tx_en(tx_en),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .cts_ok(cts_ok),
    .parity_en(parity_en), .parity_odd(parity_odd), .two_stop(two_stop),
    .force_perr(force_perr), .fifo_pop(fifo_pop), .busy(busy),
    .raw_bit(raw_bit), .sub(sub)
  );

  tx_line_encoder #(.OVS(OVS), .PULSE_SUBS(PULSE_SUBS)) u_enc (
    .clk(clk), .rst(rst), .raw_bit(raw_bit), .sub(sub),
    .send_break(send_break), .irda_en(irda_en), .irda_inv(irda_inv),
    .txd(txd)
  );
endmodule

// File: rtl/uart_tx_engine_chk.sv
`timescale 1ns/1ps
module uart_tx_engine_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic tx_en,
  input logic fifo_valid,
  input logic fifo_pop,
  input logic cts_bypass,
  input logic cts_delta_clr,
  input logic cts_level,
  input logic cts_delta,
  input logic send_break,
  input logic irda_en,
  input logic txd,
  input logic busy
);
  // R9: pop is a single-cycle pulse
  assert_pop_single_R9: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);

  // R9: a pop means a frame is under way
  assert_busy_on_pop_R9: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> busy);

  // R8: a frame starts only with data offered and transmission enabled
  assert_pop_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> ($past(fifo_valid) && $past(tx_en) && $past(bit_tick)));

  // R4: start only while the sampled clear-to-send level is asserted
  assert_cts_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop && !$past(cts_bypass)) |-> !$past(cts_level));

  // R7: break holds the plain line low
  assert_break_low_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(send_break) && !$past(irda_en)) |-> !txd);

  // R6: clear strobe without a sampling tick empties the flag
  assert_delta_clear_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cts_delta_clr) && !$past(bit_tick)) |-> !cts_delta);

  // R6: sampled level only moves on a tick
  assert_level_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_tick) |-> $stable(cts_level));

  // R12: no progress without a tick
  assert_busy_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_tick) |-> $stable(busy));
endmodule

bind uart_tx_engine uart_tx_engine_chk u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en),
  .fifo_valid(fifo_valid), .fifo_pop(fifo_pop), .cts_bypass(cts_bypass),
  .cts_delta_clr(cts_delta_clr), .cts_level(cts_level), .cts_delta(cts_delta),
  .send_break(send_break), .irda_en(irda_en), .txd(txd), .busy(busy)
);

// File: tb/sim_uart_tx_engine.sv
`timescale 1ns/1ps
module sim_uart_tx_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_on = 1'b1;
  logic tx_en = 1'b1, fifo_valid = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic cts_n = 1'b1, cts_bypass = 1'b0, cts_delta_clr = 1'b0;
  logic parity_en = 1'b0, parity_odd = 1'b0, two_stop = 1'b0, force_perr = 1'b0;
  logic send_break = 1'b0, irda_en = 1'b0, irda_inv = 1'b0;
  logic fifo_pop, cts_level, cts_delta, txd, busy;

  int checks = 0;
  int fails  = 0;
  int idle_err;

  always #2 clk = ~clk;

  uart_tx_engine u0 (
    .clk(clk), .rst(rst), .bit_tick(tick_on), .tx_en(tx_en),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .cts_n(cts_n), .cts_bypass(cts_bypass), .cts_delta_clr(cts_delta_clr),
    .cts_level(cts_level), .cts_delta(cts_delta), .parity_en(parity_en),
    .parity_odd(parity_odd), .two_stop(two_stop), .force_perr(force_perr),
    .send_break(send_break), .irda_en(irda_en), .irda_inv(irda_inv),
    .txd(txd), .busy(busy)
  );

  // {data[7:0], parity_en, parity_odd, two_stop, force_perr, irda_en, irda_inv}
  localparam logic [13:0] VEC [8] = '{
    {8'h55, 6'b000000},
    {8'hA3, 6'b100000},
    {8'hA3, 6'b110000},
    {8'h0F, 6'b001000},
    {8'h81, 6'b100100},
    {8'h3C, 6'b111000},
    {8'h96, 6'b000010},
    {8'h4D, 6'b100011}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int frame_len(input logic [13:0] v);
    return 10 + int'(v[5]) + int'(v[3]);
  endfunction

  function automatic logic [11:0] frame_bits(input logic [13:0] v);
    logic [11:0] f;
    int n;
    f = '1;
    f[0] = 1'b0;
    f[8:1] = v[13:6];
    n = 9;
    if (v[5]) begin
      f[9] = (^v[13:6]) ^ v[4] ^ v[2];
      n = 10;
    end
    for (int i = n; i < 12; i++) f[i] = 1'b1;
    return f;
  endfunction

  function automatic logic [11:0] len_mask(input int n);
    return 12'((1 << n) - 1);
  endfunction

  task automatic wait_pop(output logic got, input int limit);
    got = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (fifo_pop) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  // mid: 0 none, 1 raise cts_n at cycle 40, 2 clear tx_en at cycle 40
  task automatic run_frame(input logic [13:0] v, input int mid,
                           output logic [11:0] obs, output int busy_last, output logic started);
    int nb;
    @(negedge clk);
    fifo_data  = v[13:6];
    parity_en  = v[5];  parity_odd = v[4]; two_stop = v[3];
    force_perr = v[2];  irda_en    = v[1]; irda_inv = v[0];
    fifo_valid = 1'b1;
    wait_pop(started, 100);
    fifo_valid = 1'b0;
    obs = '0;
    busy_last = busy ? 0 : -1;
    idle_err = 0;
    nb = frame_len(v);
    if (started) begin
      for (int cyc = 1; cyc <= 16 * nb + 2; cyc++) begin
        @(negedge clk);
        if (cyc == 40 && mid == 1) cts_n = 1'b1;
        if (cyc == 40 && mid == 2) tx_en = 1'b0;
        if (busy) busy_last = cyc;
        if (cyc / 16 < nb) begin
          if (irda_en) begin
            if (cyc % 16 == 2) obs[cyc / 16] = ~(txd ^ irda_inv);
            if (cyc % 16 == 8 && txd != irda_inv) idle_err++;
          end else if (cyc % 16 == 8) begin
            obs[cyc / 16] = txd;
          end
        end
      end
    end
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] obs, expf, m;
    int bl, nb;
    logic st;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state, R6 reset flags
    chk(txd == 1'b1, "R11 txd idle", txd, 1);
    chk(busy == 1'b0 && fifo_pop == 1'b0, "R11 busy/pop", {busy, fifo_pop}, 0);
    chk(cts_level == 1'b1 && cts_delta == 1'b0, "R6 reset cts", {cts_level, cts_delta}, 2);

    // R6 change detection and clear
    cts_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cts_level == 1'b0 && cts_delta == 1'b1, "R6 delta set", {cts_level, cts_delta}, 1);
    cts_delta_clr = 1'b1;
    @(negedge clk);
    cts_delta_clr = 1'b0;
    repeat (4) @(negedge clk);
    chk(cts_delta == 1'b0, "R6 delta cleared", cts_delta, 0);

    // Table of frames: R1 R2 R3 R9 R10
    foreach (VEC[i]) begin
      run_frame(VEC[i], 0, obs, bl, st);
      nb = frame_len(VEC[i]);
      m = len_mask(nb);
      expf = frame_bits(VEC[i]) & m;
      chk(st, "R9 pop seen", int'(st), 1);
      chk((obs & m) == expf, VEC[i][1] ? "R10 irda frame" :
          (VEC[i][2] ? "R3 forced parity" : (VEC[i][5] ? "R2 parity frame" : "R1 frame")),
          int'(obs & m), int'(expf));
      chk(bl == 16 * nb - 1, "R9 busy length", bl, 16 * nb - 1);
      if (VEC[i][1]) chk(idle_err == 0, "R10 no pulse on one", idle_err, 0);
    end
    irda_en = 1'b0; irda_inv = 1'b0;

    // R12 no start without tick; level holds
    tick_on = 1'b0;
    @(negedge clk);
    fifo_valid = 1'b1;
    cts_n = 1'b1;
    wait_pop(st, 30);
    chk(!st, "R12 no start without tick", int'(st), 0);
    chk(cts_level == 1'b0, "R6 level holds without tick", cts_level, 0);
    fifo_valid = 1'b0;
    cts_n = 1'b0;
    @(negedge clk);
    tick_on = 1'b1;

    // R4 blocked by cts negated
    cts_n = 1'b1;
    repeat (3) @(negedge clk);
    fifo_valid = 1'b1;
    wait_pop(st, 40);
    chk(!st && txd == 1'b1, "R4 blocked by cts", int'(st), 0);
    fifo_valid = 1'b0;

    // R5 bypass ignores cts
    cts_bypass = 1'b1;
    run_frame({8'hC5, 6'b000000}, 0, obs, bl, st);
    m = len_mask(10);
    chk(st && (obs & m) == (frame_bits({8'hC5, 6'b000000}) & m), "R5 bypass frame",
        int'(obs & m), int'(frame_bits({8'hC5, 6'b000000}) & m));
    cts_bypass = 1'b0;
    cts_n = 1'b0;
    repeat (3) @(negedge clk);

    // R4 cts rise mid-frame: frame completes, then holds
    run_frame({8'h6E, 6'b100000}, 1, obs, bl, st);
    m = len_mask(11);
    chk((obs & m) == (frame_bits({8'h6E, 6'b100000}) & m), "R4 mid-frame completes",
        int'(obs & m), int'(frame_bits({8'h6E, 6'b100000}) & m));
    chk(bl == 16 * 11 - 1, "R4 busy through frame", bl, 16 * 11 - 1);
    fifo_valid = 1'b1;
    wait_pop(st, 40);
    chk(!st, "R4 no start after rise", int'(st), 0);
    fifo_valid = 1'b0;
    cts_n = 1'b0;
    repeat (3) @(negedge clk);

    // R8 disable mid-frame: completes, then no new frame
    run_frame({8'h39, 6'b001000}, 2, obs, bl, st);
    m = len_mask(11);
    chk((obs & m) == (frame_bits({8'h39, 6'b001000}) & m), "R8 frame finishes",
        int'(obs & m), int'(frame_bits({8'h39, 6'b001000}) & m));
    chk(bl == 16 * 11 - 1, "R8 busy until end", bl, 16 * 11 - 1);
    fifo_valid = 1'b1;
    wait_pop(st, 40);
    chk(!st, "R8 no start when disabled", int'(st), 0);
    fifo_valid = 1'b0;
    tx_en = 1'b1;

    // R7 break: all zeros
    send_break = 1'b1;
    run_frame({8'hFF, 6'b000000}, 0, obs, bl, st);
    m = len_mask(10);
    chk(st && (obs & m) == 12'h000, "R7 break zeros", int'(obs & m), 0);
    chk(txd == 1'b0, "R7 break holds idle line", txd, 0);
    send_break = 1'b0;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R7 line released", txd, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule